// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table of segment translations. Each slot holds an effective-segment word and a virtual-segment word. A combinational lookup port matches an effective address against every slot in the same cycle. A slot matches as a 256 MB segment or as a 1 TB segment, according to a size field stored in that slot. The lookup returns the winning slot and its virtual-segment word.

Maintenance works through a command stream. It can write a slot, with checks for illegal encodings. It can read either word of a slot by index, find the virtual-segment word that covers an address, invalidate the one entry that covers an address, or invalidate every slot except slot 0. Invalidations raise a one-cycle local or global TLB-flush request.

The command channel uses valid/ready, and so does the response channel. Every accepted command returns exactly one response. A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge. Its response appears in the next cycle. The response then stays on the pins until `rsp_ready` is high at an edge. `cmd_ready` is high whenever the response register is empty or is being drained in that cycle. A stalled consumer therefore holds back the command stream with no extra buffering.

Top module: `slb_array`

## Requirements
- R1: After reset every slot is zero and therefore invalid. No lookup hits, and `rsp_valid`, `flush_local` and `flush_global` are low.
- R2: Slot word layout. Bit 27 of the effective-segment word is the valid bit. Bits 63:62 of the virtual-segment word are the size field, where 00 means 256 MB and 01 means 1 TB. A 256 MB slot hits when its effective-segment word equals the address with bits 27:0 cleared and bit 27 then set.
- R3: A 1 TB slot hits when its effective-segment word equals the address with bits 39:0 cleared and bit 27 set. A 1 TB slot with any of bits 39:28 set can never hit.
- R4: On the lookup port, `lk_hit`, `lk_slot` and `lk_vsid` follow `lk_ea` in the same cycle. When several slots hit, the lowest-numbered slot wins. On a miss, `lk_vsid` is all ones.
- R5: Write (op 0). The slot index is `cmd_addr[11:0]`. The effective-segment word stored is `cmd_addr` with bits 11:0 cleared, and the virtual-segment word stored is `cmd_data`. The response has err=0.
- R6: A write is rejected (err=1, table unchanged) in any of these cases: the index is at or above NUM_SLOTS; any of `cmd_addr[26:12]` is set; `cmd_data[63]` is set; or the size field is 01 while `en_1t` is low.
- R7: A write is also rejected when its page-size code {`cmd_data[8]`, `cmd_data[5:4]`} is not in the PSIZE_CODES table. The default table holds 000, 101 and 100.
- R8: Read-effective (op 1) and read-virtual (op 2) return the indexed slot's word. An index at or above NUM_SLOTS returns err=1 with data 0.
- R9: Find (op 3) returns the virtual-segment word of the slot that wins for `cmd_addr`, or all ones on a miss. err is 0 in both cases.
- R10: Invalidate-one (op 4 local, op 5 global) clears only the valid bit of the winning slot for `cmd_addr`. It then pulses `flush_local` (op 4) or `flush_global` (op 5) for one cycle, in the first cycle of its response. A miss changes nothing and raises no flush.
- R11: Invalidate-all (op 6) clears the valid bit of slots 1 to NUM_SLOTS-1 and leaves slot 0 untouched. It pulses `flush_local` only if one of those slots was valid.
- R12: The response arrives in the cycle after acceptance. Data and err hold stable while `rsp_ready` is low. `cmd_ready` equals `!rsp_valid || rsp_ready`. Writes and invalidates return data 0.
- R13: Op 7 returns err=1 and changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_1t | input | 1 | Allows 1 TB segments to be written |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted at this edge if valid |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 64 | Index, segment word or address operand |
| cmd_data | input | 64 | Virtual-segment word for writes |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 64 | Response data |
| rsp_err | output | 1 | Command rejected or index out of range |
| flush_local | output | 1 | One-cycle local TLB-flush request |
| flush_global | output | 1 | One-cycle global TLB-flush request |
| lk_ea | input | 64 | Lookup effective address |
| lk_hit | output | 1 | Lookup found a slot |
| lk_slot | output | SLOT_W | Winning slot index |
| lk_vsid | output | 64 | Winning virtual-segment word, all ones on miss |

## Verification
Several conditions are hard to reach from the ports:
- **Priority between overlapping slots.** Writes never check for duplicates. To test it, the stimulus writes two slots with the same 256 MB segment, then invalidates one by address and watches the lookup fall through to the higher slot.
- **The slot-0 exemption and the conditional flush.** These need invalidate-all to run twice: once with upper slots valid, and once when only slot 0 is left.
- **Response holding under back-pressure.** A burst of reads is issued while `rsp_ready` is toggled pseudo-randomly. A reference model is compared against the design on every cycle.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int EA_W       = 64;
  localparam int IDX_W      = 12;
  localparam int VALID_BIT  = 27;
  localparam int SEG256_LSB = 28;
  localparam int SEG1T_LSB  = 40;
  localparam int PS_W       = 3;

  localparam logic [1:0] SZ_256M = 2'b00;
  localparam logic [1:0] SZ_1T   = 2'b01;

  typedef logic [EA_W-1:0] word_t;

  typedef enum logic [2:0] {
    OP_WRITE      = 3'd0,
    OP_RD_ESID    = 3'd1,
    OP_RD_VSID    = 3'd2,
    OP_FIND       = 3'd3,
    OP_INV_LOCAL  = 3'd4,
    OP_INV_GLOBAL = 3'd5,
    OP_INV_ALL    = 3'd6,
    OP_NONE       = 3'd7
  } slb_op_e;

  // Compare key: address masked to the segment boundary, valid bit forced on.
  function automatic word_t seg_key(word_t ea, int lsb);
    word_t k;
    k = ea;
    for (int b = 0; b < lsb; b++) k[b] = 1'b0;
    k[VALID_BIT] = 1'b1;
    return k;
  endfunction
endpackage

// File: rtl/slb_match.sv
module slb_match
  import slb_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  word_t                  ea,
  input  word_t [NUM_SLOTS-1:0]  esid_tab,
  input  logic  [NUM_SLOTS-1:0][1:0] size_tab,
  output logic  [NUM_SLOTS-1:0]  hit_vec
);
  word_t key_256m;
  word_t key_1t;

  assign key_256m = seg_key(ea, SEG256_LSB);
  assign key_1t   = seg_key(ea, SEG1T_LSB);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    logic hit_small, hit_large;
    assign hit_small = (esid_tab[g] == key_256m) && (size_tab[g] == SZ_256M);
    assign hit_large = (esid_tab[g] == key_1t)   && (size_tab[g] == SZ_1T);
    assign hit_vec[g] = hit_small || hit_large;
  end
endmodule

// File: rtl/slb_pick.sv
module slb_pick #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] hit_vec,
  output logic                 any_hit,
  output logic [SLOT_W-1:0]    first
);
  always_comb begin
    first = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) first = SLOT_W'(i);
    end
  end
  assign any_hit = |hit_vec;
endmodule

// File: rtl/slb_wcheck.sv
module slb_wcheck
  import slb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_PSIZE = 3,
  parameter logic [NUM_PSIZE*PS_W-1:0] PSIZE_CODES = {3'b100, 3'b101, 3'b000}
) (
  input  logic [IDX_W-1:0]           slot_f,
  input  logic [VALID_BIT-1:IDX_W]   rsv_f,
  input  logic [1:0]                 size_f,
  input  logic [PS_W-1:0]            ps_f,
  input  logic                       en_1t,
  output logic                       write_ok
);
  logic [NUM_PSIZE-1:0] ps_hit;
  logic slot_ok, rsv_ok, size_ok, large_ok;

  for (genvar p = 0; p < NUM_PSIZE; p++) begin : g_ps
    assign ps_hit[p] = (ps_f == PSIZE_CODES[p*PS_W +: PS_W]);
  end

  assign slot_ok  = slot_f < IDX_W'(NUM_SLOTS);
  assign rsv_ok   = (rsv_f == '0);
  assign size_ok  = !size_f[1];
  assign large_ok = !(size_f == SZ_1T && !en_1t);
  assign write_ok = slot_ok && rsv_ok && size_ok && large_ok && (|ps_hit);
endmodule

// File: rtl/slb_array.sv
module slb_array
  import slb_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_PSIZE = 3,
  parameter logic [NUM_PSIZE*3-1:0] PSIZE_CODES = {3'b100, 3'b101, 3'b000},
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_1t,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [63:0]       cmd_addr,
  input  logic [63:0]       cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_data,
  output logic              rsp_err,
  output logic              flush_local,
  output logic              flush_global,
  input  logic [63:0]       lk_ea,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_slot,
  output logic [63:0]       lk_vsid
);
  word_t [NUM_SLOTS-1:0]       esid_q;
  word_t [NUM_SLOTS-1:0]       vsid_q;
  logic  [NUM_SLOTS-1:0][1:0]  size_tab;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_size
    assign size_tab[g] = vsid_q[g][EA_W-1:EA_W-2];
  end

  // Translation lookup path
  logic [NUM_SLOTS-1:0] lk_vec;
  slb_match #(.NUM_SLOTS(NUM_SLOTS)) u_lk_match (
    .ea(lk_ea), .esid_tab(esid_q), .size_tab(size_tab), .hit_vec(lk_vec));
  slb_pick #(.NUM_SLOTS(NUM_SLOTS)) u_lk_pick (
    .hit_vec(lk_vec), .any_hit(lk_hit), .first(lk_slot));
  assign lk_vsid = lk_hit ? vsid_q[lk_slot] : '1;

  // Command path: associative search on the operand address
  logic [NUM_SLOTS-1:0] c_vec;
  logic                 c_hit;
  logic [SLOT_W-1:0]    c_slot;
  slb_match #(.NUM_SLOTS(NUM_SLOTS)) u_cmd_match (
    .ea(cmd_addr), .esid_tab(esid_q), .size_tab(size_tab), .hit_vec(c_vec));
  slb_pick #(.NUM_SLOTS(NUM_SLOTS)) u_cmd_pick (
    .hit_vec(c_vec), .any_hit(c_hit), .first(c_slot));

  logic wr_ok;
  slb_wcheck #(.NUM_SLOTS(NUM_SLOTS), .NUM_PSIZE(NUM_PSIZE), .PSIZE_CODES(PSIZE_CODES)) u_wcheck (
    .slot_f (cmd_addr[IDX_W-1:0]),
    .rsv_f  (cmd_addr[VALID_BIT-1:IDX_W]),
    .size_f (cmd_data[EA_W-1:EA_W-2]),
    .ps_f   ({cmd_data[8], cmd_data[5:4]}),
    .en_1t  (en_1t),
    .write_ok(wr_ok));

  logic              accept;
  logic              idx_ok;
  logic [SLOT_W-1:0] sel;
  logic              upper_any;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign idx_ok    = cmd_addr[IDX_W-1:0] < IDX_W'(NUM_SLOTS);
  assign sel       = cmd_addr[SLOT_W-1:0];

  always_comb begin
    upper_any = 1'b0;
    for (int i = 1; i < NUM_SLOTS; i++) upper_any = upper_any | esid_q[i][VALID_BIT];
  end

  word_t nx_data;
  logic  nx_err, nx_fl, nx_fg, wr_en, clr_one, clr_all;

  always_comb begin
    nx_data = '0;
    nx_err  = 1'b0;
    nx_fl   = 1'b0;
    nx_fg   = 1'b0;
    wr_en   = 1'b0;
    clr_one = 1'b0;
    clr_all = 1'b0;
    case (slb_op_e'(cmd_op))
      OP_WRITE: begin
        if (wr_ok) wr_en = 1'b1;
        else       nx_err = 1'b1;
      end
      OP_RD_ESID: begin
        if (idx_ok) nx_data = esid_q[sel];
        else        nx_err  = 1'b1;
      end
      OP_RD_VSID: begin
        if (idx_ok) nx_data = vsid_q[sel];
        else        nx_err  = 1'b1;
      end
      OP_FIND:
        nx_data = c_hit ? vsid_q[c_slot] : '1;
      OP_INV_LOCAL: begin
        clr_one = c_hit;
        nx_fl   = c_hit;
      end
      OP_INV_GLOBAL: begin
        clr_one = c_hit;
        nx_fg   = c_hit;
      end
      OP_INV_ALL: begin
        clr_all = 1'b1;
        nx_fl   = upper_any;
      end
      default: nx_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      esid_q       <= '0;
      vsid_q       <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_err      <= 1'b0;
      flush_local  <= 1'b0;
      flush_global <= 1'b0;
    end else begin
      flush_local  <= accept && nx_fl;
      flush_global <= accept && nx_fg;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_data  <= nx_data;
        rsp_err   <= nx_err;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (accept && wr_en) begin
        esid_q[sel] <= {cmd_addr[EA_W-1:IDX_W], {IDX_W{1'b0}}};
        vsid_q[sel] <= cmd_data;
      end
      if (accept && clr_one) esid_q[c_slot][VALID_BIT] <= 1'b0;
      if (accept && clr_all) begin
        for (int i = 1; i < NUM_SLOTS; i++) esid_q[i][VALID_BIT] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slb_array_chk.sv
module slb_array_chk #(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [63:0]       rsp_data,
  input logic              rsp_err,
  input logic              flush_local,
  input logic              flush_global,
  input logic              lk_hit,
  input logic [SLOT_W-1:0] lk_slot
);
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rsp_valid && !lk_hit && !flush_local && !flush_global);

  assert_slot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (int'(lk_slot) < NUM_SLOTS));

  assert_flush_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_local && flush_global));

  assert_flush_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_local || flush_global) |-> $past(cmd_valid && cmd_ready));

  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));

  assert_backpressure_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready);
endmodule

bind slb_array slb_array_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/slb_array_bench.sv
`timescale 1ns/1ps
module slb_array_bench;
  localparam int N = 8;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_1t = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [63:0] cmd_addr = '0, cmd_data = '0;
  logic rsp_ready = 1'b1;
  logic [63:0] lk_ea = '0;
  logic cmd_ready, rsp_valid, rsp_err, flush_local, flush_global, lk_hit;
  logic [63:0] rsp_data, lk_vsid;
  logic [2:0] lk_slot;

  always #2 clk = ~clk;

  slb_array u_slb_array (
    .clk(clk), .rst_n(rst_n), .en_1t(en_1t),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .flush_local(flush_local), .flush_global(flush_global),
    .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_vsid(lk_vsid));

  int nchecks = 0, nfail = 0;
  bit done = 0, stall_mode = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [63:0] m_esid [N];
  logic [63:0] m_vsid [N];
  bit m_rv, m_re, m_fl, m_fg;
  logic [63:0] m_rd;
  string m_tag = "R12";

  function automatic int m_find(logic [63:0] ea);
    logic [63:0] k_s, k_l;
    k_s = (ea & ~64'h0FFF_FFFF) | 64'h0800_0000;
    k_l = (ea & ~64'hFF_FFFF_FFFF) | 64'h0800_0000;
    for (int i = 0; i < N; i++) begin
      if (m_esid[i] == k_s && m_vsid[i][63:62] == 2'b00) return i;
      if (m_esid[i] == k_l && m_vsid[i][63:62] == 2'b01) return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_esid[i] = '0; m_vsid[i] = '0; end
      m_rv = 0; m_re = 0; m_rd = '0; m_fl = 0; m_fg = 0;
    end else begin
      bit acc;
      int slot, hit;
      logic [2:0] pc;
      m_fl = 0; m_fg = 0;
      acc = cmd_valid && (!m_rv || rsp_ready);
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc) begin
        m_rv = 1; m_rd = '0; m_re = 0;
        slot = int'(cmd_addr[11:0]);
        case (cmd_op)
          3'd0: begin
            pc = {cmd_data[8], cmd_data[5:4]};
            if (slot >= N || cmd_addr[26:12] != 0 || cmd_data[63] ||
                (cmd_data[63:62] == 2'b01 && !en_1t)) begin
              m_re = 1; m_tag = "R6 write reject";
            end else if (!(pc == 3'b000 || pc == 3'b101 || pc == 3'b100)) begin
              m_re = 1; m_tag = "R7 page-size reject";
            end else begin
              m_tag = "R5 write";
              m_esid[slot] = cmd_addr & ~64'hFFF;
              m_vsid[slot] = cmd_data;
            end
          end
          3'd1, 3'd2: begin
            m_tag = "R8 indexed read";
            if (slot >= N) m_re = 1;
            else m_rd = (cmd_op == 3'd1) ? m_esid[slot] : m_vsid[slot];
          end
          3'd3: begin
            m_tag = "R9 find";
            hit = m_find(cmd_addr);
            m_rd = (hit >= 0) ? m_vsid[hit] : ONES;
          end
          3'd4, 3'd5: begin
            m_tag = "R10 invalidate one";
            hit = m_find(cmd_addr);
            if (hit >= 0) begin
              m_esid[hit][27] = 1'b0;
              if (cmd_op == 3'd4) m_fl = 1; else m_fg = 1;
            end
          end
          3'd6: begin
            m_tag = "R11 invalidate all";
            for (int i = 1; i < N; i++) begin
              if (m_esid[i][27]) begin m_fl = 1; m_esid[i][27] = 1'b0; end
            end
          end
          default: begin m_tag = "R13 unused op"; m_re = 1; end
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int idx;
      chk("R12 cmd_ready", 64'(cmd_ready), 64'(!m_rv || rsp_ready));
      chk("R12 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) begin
        chk({m_tag, " rsp_data"}, rsp_data, m_rd);
        chk({m_tag, " rsp_err"}, 64'(rsp_err), 64'(m_re));
      end
      chk("R10/R11 flush_local", 64'(flush_local), 64'(m_fl));
      chk("R10 flush_global", 64'(flush_global), 64'(m_fg));
      idx = m_find(lk_ea);
      chk("R2/R3 lk_hit", 64'(lk_hit), 64'(idx >= 0));
      if (idx >= 0) begin
        chk("R4 lk_slot priority", 64'(lk_slot), 64'(idx));
        chk("R4 lk_vsid", lk_vsid, m_vsid[idx]);
      end else begin
        chk("R4 lk_vsid miss", lk_vsid, ONES);
      end
    end
  end

  // ---------------- lookup address and consumer drivers ----------------
  logic [63:0] ea_list [8];
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  initial begin
    ea_list[0] = 64'h0000_0012_3456_789A;
    ea_list[1] = 64'h0000_56AB_CDEF_0123;
    ea_list[2] = 64'h8000_0000_F123_4567;
    ea_list[3] = 64'h0000_AB00_1234_0000;
    ea_list[4] = 64'h0000_0099_9000_0000;
    ea_list[5] = 64'h0000_0012_2FFF_FFFF;
    ea_list[6] = 64'h0000_5700_0000_0000;
    ea_list[7] = 64'h0000_0000_0000_0000;
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    lk_ea = ea_list[cyc % 8];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rsp_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] d);
    bit acc;
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    do begin
      @(negedge clk); acc = cmd_ready;
      @(posedge clk); #1;
    end while (!acc);
    cmd_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nchecks++; nfail++;
      $display("FAIL R12 watchdog expired actual=hung expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 reset flush", 64'({flush_local, flush_global}), 64'd0);
    for (int i = 0; i < 8; i++) begin
      lk_ea = ea_list[i]; #0.1;
      chk("R1 reset lookup miss", 64'(lk_hit), 64'd0);
    end
    idle(8);
    // R5: legal writes
    issue(3'd0, 64'h0000_0012_3800_0000, 64'h0000_1111_2222_0000);
    issue(3'd0, 64'h0000_5600_0800_0001, 64'h4000_3333_4444_0110);
    issue(3'd0, 64'h0000_0012_3800_0002, 64'h0000_5555_6666_0100);
    issue(3'd0, 64'h8000_0000_F800_0005, 64'h0000_7777_0000_0000);
    issue(3'd0, 64'h0000_AB00_1800_0007, 64'h4000_0000_0000_0000); // R3: unreachable 1 TB slot
    issue(3'd0, 64'h0000_0099_9000_0006, 64'h0000_0000_0000_0000); // R2: valid bit clear
    // R6 and R7: rejected writes
    issue(3'd0, 64'h0000_0012_3800_0008, 64'h0);
    issue(3'd0, 64'h0000_0012_3800_0FFF, 64'h0);
    issue(3'd0, 64'h0000_0012_3800_1003, 64'h0);
    issue(3'd0, 64'h0000_0012_3800_0003, 64'h8000_0000_0000_0000);
    issue(3'd0, 64'h0000_0012_3800_0003, 64'hC000_0000_0000_0000);
    en_1t = 0;
    issue(3'd0, 64'h0000_5600_0800_0003, 64'h4000_0000_0000_0000);
    en_1t = 1;
    issue(3'd0, 64'h0000_0012_3800_0003, 64'h0000_0000_0000_0010);
    idle(16);
    // R8: indexed reads including out of range
    for (int s = 0; s < 10; s++) issue(3'd1, 64'(s), 64'h0);
    for (int s = 0; s < 10; s++) issue(3'd2, 64'(s), 64'h0);
    // R9: find hit and miss
    issue(3'd3, ea_list[0], 64'h0);
    issue(3'd3, ea_list[1], 64'h0);
    issue(3'd3, ea_list[3], 64'h0);
    issue(3'd3, ea_list[5], 64'h0);
    // R10: local, then global, then miss
    issue(3'd4, 64'h0000_0012_3000_0040, 64'h0);
    idle(8);
    issue(3'd5, 64'h0000_0012_3FFF_0000, 64'h0);
    idle(2);
    issue(3'd5, 64'h0000_0012_3000_0000, 64'h0);
    issue(3'd1, 64'd0, 64'h0);
    issue(3'd1, 64'd2, 64'h0);
    // R11: invalidate all with upper slots valid, then with only slot 0
    issue(3'd0, 64'h0000_0012_3800_0000, 64'h0000_1111_2222_0000);
    issue(3'd6, 64'h0, 64'h0);
    idle(8);
    issue(3'd6, 64'h0, 64'h0);
    issue(3'd1, 64'd0, 64'h0);
    issue(3'd1, 64'd1, 64'h0);
    idle(8);
    // R13: unused op
    issue(3'd7, 64'h0000_0012_3800_0000, 64'h0);
    issue(3'd1, 64'd0, 64'h0);
    // R12: back-pressure burst
    issue(3'd0, 64'h0000_0044_0800_0004, 64'h0000_00AA_0000_0110);
    stall_mode = 1;
    for (int r = 0; r < 3; r++) begin
      for (int s = 0; s < 9; s++) issue(3'(1 + (s % 3)), 64'(s), 64'h0);
      issue(3'd4, 64'h0000_0044_0000_0000, 64'h0);
      issue(3'd0, 64'h0000_0044_0800_0004, 64'h0000_00AA_0000_0110);
    end
    stall_mode = 0;
    idle(10);
    done = 1;
    summary();
    $finish;
  end
endmodule